// File: doc/BRIEF.md
# Power-Management Event Register Block with SCI Generation

This block holds the event registers of a power-management controller and presents them on a simple I/O bus. An event status register, an event enable register and a control register sit at fixed offsets inside a relocatable window. A free-running timer can also be read from that window. The window base comes from a configuration word masked to the window size, and a configuration enable bit turns the window on.

The block drives one level-sensitive system control interrupt (SCI). The SCI is high while any of four event classes is both pending and enabled: timer, global lock, power button and real-time clock. It is also high while the hot-plug bit of an external general-purpose-event status/enable pair is set on both sides.

Writes to the advanced-power-management control port can switch the SCI mode bit on or off. If the configuration allows it, any such write also raises a one-cycle system-management interrupt (SMI) pulse.

Top module: `pm_evt_sci_ctrl`

## Requirements
- R1: Inside the window, the register offsets are fixed:
  - Offset 0x00 is event status, offset 0x02 is event enable, offset 0x04 is control and offset 0x08 is the timer.
  - The timer is read-only.
  - `io_rdata` follows `io_addr` combinationally.
  - Every other offset reads zero, and a write to it changes no register.
- R2: The window is hit only when `cfg_map_ctl` bit 0 is set and `io_addr & 0xFFC0` equals `cfg_base & 0xFFC0`. When the window is not hit, reads return zero and writes change no register.
- R3: Event status implements bit 0 (timer), bit 5 (global lock), bit 8 (power button) and bit 10 (real-time clock). Every other status bit reads 0. Writing 1 to a status bit clears it at the next clock edge, and writing 0 leaves it unchanged.
- R4: The event enable register stores all 16 written bits. The control register likewise stores all 16 written bits, and bit 0 of control is the SCI mode bit.
- R5: `sci_o` is high exactly when either of these holds:
  - status AND enable has any of bits 0, 5, 8 or 10 set;
  - `gpe_sts` bit 1 and `gpe_en` bit 1 are both set.
  `sci_o` follows the register contents and the GPE inputs with no added delay.
- R6: The timer is a `TMR_W`-bit counter. It is 0 in the reset state and rises by one on every clock edge, wrapping at its full count. It reads at offset 0x08 zero-extended.
- R7: On the edge where the timer's top bit changes, timer status (bit 0) sets, but only if enable bit 0 is set at that time. While enable bit 0 is clear, the timer never sets its status.
- R8: A write of 0xF1 on the APM port sets control bit 0, and a write of 0xF0 clears it; other values leave it unchanged. An APM write in the same cycle as a bus write to control takes precedence for bit 0.
- R9: Every APM write, whatever its value, makes `smi_o` high for exactly the following cycle when `cfg_smi_ctl` bit 1 is set. `smi_o` is otherwise low.
- R10: A one-cycle pulse on `pwrbtn_evt`, `gbl_evt` or `rtc_evt` sets status bit 8, 5 or 10 respectively at that edge. A hardware set in the same cycle as a write-1-to-clear of that bit leaves the bit set.
- R11: While `rst_n` is low, all of the following are zero: status, enable, control, timer, `sci_o` and `smi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 32 | I/O read data for `io_addr` |
| cfg_base | input | 32 | Window base field; bits [5:0] are masked off |
| cfg_map_ctl | input | 8 | Window control byte; bit 0 enables decode |
| cfg_smi_ctl | input | 8 | SMI control byte; bit 1 allows SMI on APM writes |
| apm_wr | input | 1 | APM control-port write strobe |
| apm_data | input | 8 | APM control-port data |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| gbl_evt | input | 1 | Global-lock event pulse |
| rtc_evt | input | 1 | Real-time-clock event pulse |
| gpe_sts | input | 8 | General-purpose-event status byte |
| gpe_en | input | 8 | General-purpose-event enable byte |
| sci_o | output | 1 | Level-sensitive system control interrupt |
| smi_o | output | 1 | One-cycle SMI pulse |

## Verification
The SCI is driven by each of the four event sources and by the GPE pair on its own. Each source is first left pending with its enable clear and then with it set, which shows that the SCI depends on the masked product rather than on status alone.

Status writes use three kinds of pattern: all-zero data, a single set bit, and data with unimplemented bits set. These show write-one-to-clear apart from plain storage.

Accesses are made with the window disabled, with an address just outside the masked base, and at an unused offset. These show decode gating apart from register selection.

The timer is left running both with its enable clear and with it set, so that a status set caused by the top-bit change can be told from one that is always on.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

   // Status / enable bit positions (also the SCI source positions)
   localparam int TMR_BIT    = 0;
   localparam int GBL_BIT    = 5;
   localparam int PWRBTN_BIT = 8;
   localparam int RTC_BIT    = 10;

   localparam logic [15:0] STS_IMPL =
      (16'h1 << TMR_BIT) | (16'h1 << GBL_BIT) | (16'h1 << PWRBTN_BIT) | (16'h1 << RTC_BIT);

   // Control bit toggled by APM writes
   localparam int SCI_MODE_BIT = 0;

   // Register offsets inside the window
   localparam int OFS_STS = 'h00;
   localparam int OFS_EN  = 'h02;
   localparam int OFS_CTL = 'h04;
   localparam int OFS_TMR = 'h08;

   // APM command codes
   localparam logic [7:0] APM_SCI_ON  = 8'hF1;
   localparam logic [7:0] APM_SCI_OFF = 8'hF0;

   // Configuration byte masks
   localparam logic [7:0] MAP_EN_MASK  = 8'h01;
   localparam logic [7:0] SMI_EN_MASK  = 8'h02;
   localparam logic [7:0] GPE_HP_MASK  = 8'h02;

   typedef struct packed {
      logic pwrbtn;
      logic gbl;
      logic rtc;
   } evt_t;

   typedef struct packed {
      logic sts;
      logic en;
      logic ctl;
      logic tmr;
   } reg_sel_t;

endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
   import pm_evt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 6
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [31:0]       cfg_base,
   input  logic [7:0]        cfg_map_ctl,
   output logic              hit,
   output reg_sel_t          sel
);
   localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W)'((1 << OFS_W) - 1));

   logic [ADDR_W-1:0] base_w;
   logic [OFS_W-1:0]  ofs;

   assign base_w = ADDR_W'(cfg_base & 32'(BASE_MASK));
   assign ofs    = io_addr[OFS_W-1:0];
   assign hit    = ((cfg_map_ctl & MAP_EN_MASK) != 8'h00)
                   && ((io_addr & BASE_MASK) == base_w);

   always_comb begin
      sel     = '0;
      sel.sts = hit && (ofs == OFS_W'(OFS_STS));
      sel.en  = hit && (ofs == OFS_W'(OFS_EN));
      sel.ctl = hit && (ofs == OFS_W'(OFS_CTL));
      sel.tmr = hit && (ofs == OFS_W'(OFS_TMR));
   end
endmodule

// File: rtl/pm_evt_timer.sv
module pm_evt_timer #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TMR_W-1:0] cnt,
   output logic             msb_flip
);
   logic [TMR_W-1:0] cnt_nxt;

   assign cnt_nxt  = cnt + 1'b1;
   assign msb_flip = cnt_nxt[TMR_W-1] ^ cnt[TMR_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
   import pm_evt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_sts,
   input  logic        wr_en,
   input  logic        wr_ctl,
   input  logic [15:0] wdata,
   input  evt_t        evt,
   input  logic        tmr_flip,
   input  logic        apm_wr,
   input  logic [7:0]  apm_data,
   input  logic        smi_allow,
   output logic [15:0] sts_q,
   output logic [15:0] en_q,
   output logic [15:0] ctl_q,
   output logic        smi_q
);
   logic [15:0] set_v, clr_v, sts_d, en_d, ctl_d;

   always_comb begin
      set_v             = '0;
      set_v[PWRBTN_BIT] = evt.pwrbtn;
      set_v[GBL_BIT]    = evt.gbl;
      set_v[RTC_BIT]    = evt.rtc;
      set_v[TMR_BIT]    = tmr_flip & en_q[TMR_BIT];
   end

   assign clr_v = wr_sts ? wdata : 16'h0000;
   assign sts_d = ((sts_q & ~clr_v) | set_v) & STS_IMPL;
   assign en_d  = wr_en ? wdata : en_q;

   always_comb begin
      ctl_d = wr_ctl ? wdata : ctl_q;
      if (apm_wr && (apm_data == APM_SCI_ON))       ctl_d[SCI_MODE_BIT] = 1'b1;
      else if (apm_wr && (apm_data == APM_SCI_OFF)) ctl_d[SCI_MODE_BIT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
         ctl_q <= '0;
         smi_q <= 1'b0;
      end else begin
         sts_q <= sts_d;
         en_q  <= en_d;
         ctl_q <= ctl_d;
         smi_q <= apm_wr & smi_allow;
      end
   end
endmodule

// File: rtl/pm_evt_sci_ctrl.sv
module pm_evt_sci_ctrl
   import pm_evt_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int WIN_BYTES = 64,
   parameter int TMR_W     = 24,
   parameter bit EVT_EDGE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [15:0]       io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic [31:0]       cfg_base,
   input  logic [7:0]        cfg_map_ctl,
   input  logic [7:0]        cfg_smi_ctl,
   input  logic              apm_wr,
   input  logic [7:0]        apm_data,
   input  logic              pwrbtn_evt,
   input  logic              gbl_evt,
   input  logic              rtc_evt,
   input  logic [7:0]        gpe_sts,
   input  logic [7:0]        gpe_en,
   output logic              sci_o,
   output logic              smi_o
);
   localparam int OFS_W = $clog2(WIN_BYTES);

   // Elaboration-time parameter checks
   if ((1 << OFS_W) != WIN_BYTES || WIN_BYTES < 16) begin : g_bad_win
      $error("WIN_BYTES must be a power of two of at least 16");
   end
   if (TMR_W < 4 || TMR_W > DATA_W) begin : g_bad_tmr
      $error("TMR_W must lie between 4 and DATA_W");
   end
   if (DATA_W < 16 || ADDR_W <= OFS_W || ADDR_W > 32) begin : g_bad_bus
      $error("bus widths out of range");
   end

   logic             hit;
   reg_sel_t         sel;
   logic [TMR_W-1:0] tmr_cnt;
   logic             tmr_flip;
   logic [15:0]      sts_q, en_q, ctl_q;
   evt_t             evt_raw, evt;

   assign evt_raw = '{pwrbtn: pwrbtn_evt, gbl: gbl_evt, rtc: rtc_evt};

   // Event input variant: pulses taken as-is, or rising edges of levels
   if (EVT_EDGE) begin : g_evt_edge
      evt_t evt_prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) evt_prev <= '0;
         else        evt_prev <= evt_raw;
      end
      assign evt = evt_raw & ~evt_prev;
   end else begin : g_evt_pulse
      assign evt = evt_raw;
   end

   pm_win_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
      .io_addr     (io_addr),
      .cfg_base    (cfg_base),
      .cfg_map_ctl (cfg_map_ctl),
      .hit         (hit),
      .sel         (sel)
   );

   pm_evt_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (tmr_cnt),
      .msb_flip (tmr_flip)
   );

   pm_evt_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sts    (io_wr & sel.sts),
      .wr_en     (io_wr & sel.en),
      .wr_ctl    (io_wr & sel.ctl),
      .wdata     (io_wdata),
      .evt       (evt),
      .tmr_flip  (tmr_flip),
      .apm_wr    (apm_wr),
      .apm_data  (apm_data),
      .smi_allow ((cfg_smi_ctl & SMI_EN_MASK) != 8'h00),
      .sts_q     (sts_q),
      .en_q      (en_q),
      .ctl_q     (ctl_q),
      .smi_q     (smi_o)
   );

   always_comb begin
      io_rdata = '0;
      unique case (1'b1)
         sel.sts: io_rdata = DATA_W'(sts_q);
         sel.en:  io_rdata = DATA_W'(en_q);
         sel.ctl: io_rdata = DATA_W'(ctl_q);
         sel.tmr: io_rdata = DATA_W'(tmr_cnt);
         default: io_rdata = '0;
      endcase
   end

   assign sci_o = ((sts_q & en_q & STS_IMPL) != 16'h0000)
                  || ((gpe_sts & gpe_en & GPE_HP_MASK) != 8'h00);

   // hit is consumed through sel; keep it visible for the checker
endmodule

// File: rtl/pm_evt_sci_ctrl_chk.sv
module pm_evt_sci_ctrl_chk #(
   parameter int TMR_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             apm_wr,
   input logic [7:0]       apm_data,
   input logic             smi_allow,
   input logic             smi_o,
   input logic             sci_o,
   input logic             gpe_hp,
   input logic             win_hit,
   input logic             io_wr,
   input logic [TMR_W-1:0] tmr_cnt,
   input logic             tmr_en,
   input logic             tmr_sts,
   input logic             sci_mode,
   input logic [15:0]      en_q
);
   AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      smi_o |-> $past(apm_wr && smi_allow)); // R9

   AST_SCI_MODE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (apm_wr && apm_data == 8'hF1) |=> sci_mode); // R8

   AST_SCI_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (apm_wr && apm_data == 8'hF0) |=> !sci_mode); // R8

   AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (tmr_cnt == $past(tmr_cnt) + 1'b1)); // R6

   AST_TMR_STS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_sts) |-> $past(tmr_en)); // R7

   AST_SCI_GPE: assert property (@(posedge clk) disable iff (!rst_n)
      gpe_hp |-> sci_o); // R5

   AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !win_hit) |=> $stable(en_q)); // R2
endmodule

bind pm_evt_sci_ctrl pm_evt_sci_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .apm_wr    (apm_wr),
   .apm_data  (apm_data),
   .smi_allow (cfg_smi_ctl[1]),
   .smi_o     (smi_o),
   .sci_o     (sci_o),
   .gpe_hp    (gpe_sts[1] & gpe_en[1]),
   .win_hit   (hit),
   .io_wr     (io_wr),
   .tmr_cnt   (tmr_cnt),
   .tmr_en    (en_q[0]),
   .tmr_sts   (sts_q[0]),
   .sci_mode  (ctl_q[0]),
   .en_q      (en_q)
);

// File: tb/pm_evt_sci_ctrl_test.sv
module pm_evt_sci_ctrl_test;
   localparam int TW = 8;
   localparam logic [15:0] BASE = 16'hB000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0;
   logic [15:0] io_wdata = 16'h0;
   logic [31:0] io_rdata;
   logic [31:0] cfg_base = 32'h0000_B01F;
   logic [7:0]  cfg_map_ctl = 8'h01;
   logic [7:0]  cfg_smi_ctl = 8'h02;
   logic        apm_wr = 1'b0;
   logic [7:0]  apm_data = 8'h0;
   logic        pwrbtn_evt = 1'b0, gbl_evt = 1'b0, rtc_evt = 1'b0;
   logic [7:0]  gpe_sts = 8'h0, gpe_en = 8'h0;
   logic        sci_o, smi_o;

   int n_chk = 0, n_fail = 0;
   bit run = 1'b0, done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   pm_evt_sci_ctrl #(.TMR_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .cfg_base(cfg_base), .cfg_map_ctl(cfg_map_ctl),
      .cfg_smi_ctl(cfg_smi_ctl), .apm_wr(apm_wr), .apm_data(apm_data),
      .pwrbtn_evt(pwrbtn_evt), .gbl_evt(gbl_evt), .rtc_evt(rtc_evt),
      .gpe_sts(gpe_sts), .gpe_en(gpe_en), .sci_o(sci_o), .smi_o(smi_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_sts = 0, m_en = 0, m_ctl = 0;
   int          m_cnt = 0;
   bit          m_smi = 0;

   function automatic bit m_hit();
      return cfg_map_ctl[0] && ((io_addr & 16'hFFC0) == (cfg_base[15:0] & 16'hFFC0));
   endfunction

   function automatic logic [31:0] m_read();
      if (!m_hit()) return 32'h0;
      case (io_addr & 16'h003F)
         16'h00:  return {16'h0, m_sts};
         16'h02:  return {16'h0, m_en};
         16'h04:  return {16'h0, m_ctl};
         16'h08:  return m_cnt;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sts = 0; m_en = 0; m_ctl = 0; m_cnt = 0; m_smi = 0;
      end else begin
         logic [15:0] set_v, clr_v;
         int nxt;
         bit h;
         h = m_hit();
         nxt = (m_cnt + 1) % (1 << TW);
         set_v = 0;
         if (pwrbtn_evt) set_v[8] = 1;
         if (gbl_evt) set_v[5] = 1;
         if (rtc_evt) set_v[10] = 1;
         if (((nxt >> (TW-1)) & 1) != ((m_cnt >> (TW-1)) & 1) && m_en[0]) set_v[0] = 1;
         clr_v = (io_wr && h && io_addr[5:0] == 6'h00) ? io_wdata : 16'h0;
         m_sts = ((m_sts & ~clr_v) | set_v) & 16'h0521;
         if (io_wr && h && io_addr[5:0] == 6'h02) m_en = io_wdata;
         if (io_wr && h && io_addr[5:0] == 6'h04) m_ctl = io_wdata;
         if (apm_wr && apm_data == 8'hF1) m_ctl[0] = 1'b1;
         else if (apm_wr && apm_data == 8'hF0) m_ctl[0] = 1'b0;
         m_smi = apm_wr && cfg_smi_ctl[1];
         m_cnt = nxt;
      end
      #2;
      if (run && !done) begin
         check("R5 sci model", {31'h0, sci_o},
               {31'h0, ((m_sts & m_en & 16'h0521) != 0) || (gpe_sts[1] && gpe_en[1])});
         check("R9 smi model", {31'h0, smi_o}, {31'h0, m_smi});
         check("R1 rdata model", io_rdata, m_read());
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk); io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk); io_addr = a; #1; d = io_rdata;
   endtask

   task automatic apm(input logic [7:0] v);
      @(negedge clk); apm_wr = 1'b1; apm_data = v;
      @(negedge clk); apm_wr = 1'b0;
      #1;
   endtask

   initial begin
      logic [31:0] v, v2;
      run = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R11 sci in reset", {31'h0, sci_o}, 32'h0);
      check("R11 smi in reset", {31'h0, smi_o}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      rd(BASE + 16'h00, v); check("R11 status after reset", v, 32'h0);
      rd(BASE + 16'h04, v); check("R11 control after reset", v, 32'h0);

      // R6 timer runs
      rd(BASE + 16'h08, v); rd(BASE + 16'h08, v2);
      check("R6 timer step", v2, (v + 1) % 256);

      // R7 timer runs past MSB flips with enable clear: no status
      repeat (300) @(posedge clk);
      rd(BASE + 16'h00, v); check("R7 timer status gated off", v, 32'h0);

      // R4 enable storage, R1 unused offset ignored
      wr(BASE + 16'h02, 16'hFFFE);
      rd(BASE + 16'h02, v); check("R4 enable readback", v, 32'h0000_FFFE);
      wr(BASE + 16'h06, 16'h1234);
      rd(BASE + 16'h06, v); check("R1 unused offset reads zero", v, 32'h0);
      rd(BASE + 16'h02, v); check("R1 unused write leaves enable", v, 32'h0000_FFFE);

      // R10 power button event, R5 SCI
      @(negedge clk); pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
      rd(BASE + 16'h00, v); check("R10 power button status", v, 32'h0000_0100);
      check("R5 sci from power button", {31'h0, sci_o}, 32'h1);

      // R3 W1C: zero write keeps, unimplemented bits read 0
      wr(BASE + 16'h00, 16'h0000);
      rd(BASE + 16'h00, v); check("R3 write zero keeps", v, 32'h0000_0100);
      wr(BASE + 16'h00, 16'h0100);
      rd(BASE + 16'h00, v); check("R3 write one clears", v, 32'h0);
      check("R5 sci drops", {31'h0, sci_o}, 32'h0);

      // R10 set wins over same-cycle clear
      @(negedge clk); gbl_evt = 1'b1; rtc_evt = 1'b1;
      @(negedge clk); gbl_evt = 1'b0; rtc_evt = 1'b0;
      @(negedge clk); io_addr = BASE; io_wdata = 16'h0020; io_wr = 1'b1; gbl_evt = 1'b1;
      @(negedge clk); io_wr = 1'b0; gbl_evt = 1'b0;
      rd(BASE + 16'h00, v); check("R10 set wins over clear", v, 32'h0000_0420);
      wr(BASE + 16'h00, 16'hFFFF);

      // R2 window disabled and address off-base
      @(negedge clk); cfg_map_ctl = 8'h00;
      rd(BASE + 16'h02, v); check("R2 disabled window reads zero", v, 32'h0);
      wr(BASE + 16'h02, 16'h0000);
      @(negedge clk); cfg_map_ctl = 8'h01;
      rd(BASE + 16'h02, v); check("R2 disabled write ignored", v, 32'h0000_FFFE);
      wr(BASE + 16'h42, 16'h0000);
      rd(BASE + 16'h02, v); check("R2 off-base write ignored", v, 32'h0000_FFFE);

      // R5 GPE path
      wr(BASE + 16'h02, 16'h0000);
      @(negedge clk); gpe_sts = 8'h02; gpe_en = 8'hFD; #1;
      check("R5 gpe mismatch no sci", {31'h0, sci_o}, 32'h0);
      @(negedge clk); gpe_en = 8'h02; #1;
      check("R5 gpe sci", {31'h0, sci_o}, 32'h1);
      @(negedge clk); gpe_sts = 8'h0; gpe_en = 8'h0;

      // R8 / R9 APM
      apm(8'hF1);
      check("R9 smi pulse", {31'h0, smi_o}, 32'h1);
      rd(BASE + 16'h04, v); check("R8 sci mode on", v, 32'h1);
      check("R9 smi one cycle", {31'h0, smi_o}, 32'h0);
      apm(8'h55);
      rd(BASE + 16'h04, v); check("R8 other value keeps", v, 32'h1);
      apm(8'hF0);
      rd(BASE + 16'h04, v); check("R8 sci mode off", v, 32'h0);
      @(negedge clk); cfg_smi_ctl = 8'hFD;
      apm(8'hF1);
      check("R9 smi disallowed", {31'h0, smi_o}, 32'h0);

      // R7 timer status with enable set
      wr(BASE + 16'h02, 16'h0001);
      repeat (300) @(posedge clk);
      rd(BASE + 16'h00, v); check("R7 timer status set", v, 32'h1);
      check("R5 sci from timer", {31'h0, sci_o}, 32'h1);

      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule